// File: doc/BRIEF.md
# Fast-Page-Mode DRAM Sequencer

This block sits between a simple host port and one 4M x 4 fast-page-mode DRAM. It drives the row and column strobes, the write enable, the output enable and a shared row/column address bus. One host request moves one nibble, either a single read or a single early write. Every DRAM timing limit is a parameter counted in clock cycles.

After reset the sequencer first waits out a power-up pause with every strobe high. It then runs a wake-up train of eight CAS-before-RAS refreshes and only then offers `req_ready` to the host. While running, an interval timer asks for one CAS-before-RAS refresh at a time. That request wins over a waiting host request but never cuts into an access already under way. If no refresh has started by a hard deadline, the sequencer treats the DRAM contents as suspect. It withdraws `req_ready` and replays the full eight-refresh wake-up before it serves the host again.

Top module: `fpm_dram_seq`

## Requirements
- R1: After reset, `dram_ras_n`, `dram_cas_n`, `dram_we_n` and `dram_oe_n` are high, `req_ready` and `rd_valid` are low, and no strobe goes low for at least PAUSE_CYC clock cycles.
- R2: After the pause, WAKE_CNT (8) refreshes are issued before `req_ready` first rises. Each is CAS-before-RAS: `dram_cas_n` falls while `dram_ras_n` is high, and `dram_we_n` stays high.
- R3: With no host traffic, the next refresh's `dram_cas_n` falls REF_INT+1 cycles after `dram_ras_n` rises at the end of the previous refresh. While a refresh is due, `req_ready` is low.
- R4: A refresh never interrupts a host access, and the host access still returns correct data. `req_ready` is low whenever either strobe is low, so a request raised during a refresh waits and is served after it.
- R5: If no refresh has begun by REF_MAX cycles after the last one completed, the eight-refresh wake-up runs again before the next host request is accepted. A refresh that begins just before the deadline causes no wake-up.
- R6: The row address is on `dram_addr` when `dram_ras_n` falls and stays there for at least T_RAH cycles of RAS low. The column address is on the bus when `dram_cas_n` falls.
- R7: On a write, `dram_we_n` is low at least T_WCS cycles before `dram_cas_n` falls. `dram_dq_oe` is high with the write data when CAS falls, and `dram_oe_n` stays high while `dram_we_n` is low.
- R8: On a read, `dram_we_n` is high and `dram_oe_n` is low while CAS is low. Data is sampled only after CAS has been low for T_CAC cycles and RAS for T_RAC cycles. RAS stays low at least T_RAS cycles in every cycle.
- R9: `dram_cas_n` is high at least T_CP cycles before each fall, and `dram_ras_n` is high at least T_RP cycles before each fall.
- R10: Each read request yields exactly one `rd_valid` pulse lasting one cycle, with the sampled nibble on `rd_data`. Writes yield none.
- R11: A request is taken at a rising edge where `req_valid` and `req_ready` are both high. Each taken request produces exactly one DRAM access, where an access is a `dram_cas_n` fall with RAS low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Sequencer can take a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_row | input | ROW_W | Row address |
| req_col | input | COL_W | Column address |
| req_wdata | input | DQ_W | Write nibble |
| rd_valid | output | 1 | One-cycle read completion |
| rd_data | output | DQ_W | Read nibble |
| dram_addr | output | ADDR_W | Multiplexed row/column address |
| dram_ras_n | output | 1 | Row strobe, active low |
| dram_cas_n | output | 1 | Column strobe, active low |
| dram_we_n | output | 1 | Write enable, active low |
| dram_oe_n | output | 1 | Output enable, active low |
| dram_dq_out | output | DQ_W | Data toward DRAM |
| dram_dq_oe | output | 1 | Drive enable for dram_dq_out |
| dram_dq_in | input | DQ_W | Data from DRAM |

## Verification
The interval timer can call for a refresh in the same cycle that a host access holds the DRAM. The bench provokes this by issuing a request a fixed number of cycles after a refresh ends, so that the refresh falls due inside the access. It does this once on each side of the deadline. The outcome is judged by counting the refreshes seen before `req_ready` returns: one when the deferred refresh still starts in time, eight when the deadline was missed. In both cases the read data in flight must still be correct.

// File: rtl/fpm_dram_seq.sv
module fpm_dram_seq #(
  parameter int ROW_W     = 11,
  parameter int COL_W     = 11,
  parameter int DQ_W      = 4,
  parameter int PAUSE_CYC = 5000,
  parameter int WAKE_CNT  = 8,
  parameter int REF_INT   = 780,
  parameter int REF_MAX   = 1560,
  parameter int T_RP      = 2,
  parameter int T_RAS     = 3,
  parameter int T_RAC     = 3,
  parameter int T_CAC     = 1,
  parameter int T_RAH     = 1,
  parameter int T_CP      = 1,
  parameter int T_CSR     = 1,
  parameter int T_WCS     = 1,
  localparam int ADDR_W   = (ROW_W > COL_W) ? ROW_W : COL_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ROW_W-1:0]  req_row,
  input  logic [COL_W-1:0]  req_col,
  input  logic [DQ_W-1:0]   req_wdata,
  output logic              rd_valid,
  output logic [DQ_W-1:0]   rd_data,
  output logic [ADDR_W-1:0] dram_addr,
  output logic              dram_ras_n,
  output logic              dram_cas_n,
  output logic              dram_we_n,
  output logic              dram_oe_n,
  output logic [DQ_W-1:0]   dram_dq_out,
  output logic              dram_dq_oe,
  input  logic [DQ_W-1:0]   dram_dq_in
);

  localparam int RAH_CYC = (T_RAH < 1) ? 1 : T_RAH;
  localparam int ROW_CYC = (T_WCS > RAH_CYC) ? T_WCS - RAH_CYC : 1;
  localparam int COL_A   = (T_CAC < 1) ? 1 : T_CAC;
  localparam int COL_B   = (T_RAC > RAH_CYC) ? T_RAC - RAH_CYC : 1;
  localparam int COL_C   = (T_RAS > RAH_CYC) ? T_RAS - RAH_CYC : 1;
  localparam int COL_AB  = (COL_A > COL_B) ? COL_A : COL_B;
  localparam int COL_CYC = (COL_AB > COL_C) ? COL_AB : COL_C;
  localparam int PRE_A   = (T_RP > T_CP) ? T_RP : T_CP;
  localparam int PRE_CYC = (PRE_A < 1) ? 1 : PRE_A;
  localparam int CSR_CYC = (T_CSR < 1) ? 1 : T_CSR;
  localparam int CBR_CYC = (T_RAS < 1) ? 1 : T_RAS;
  localparam int CNT_W   = $clog2(PAUSE_CYC + ROW_CYC + RAH_CYC + COL_CYC
                                  + PRE_CYC + CSR_CYC + CBR_CYC + 1);
  localparam int RC_W    = $clog2(REF_MAX + 2);
  localparam int WK_W    = $clog2(WAKE_CNT + 1);

  localparam logic [CNT_W-1:0] L_PAUSE = CNT_W'(PAUSE_CYC - 1);
  localparam logic [CNT_W-1:0] L_ROW   = CNT_W'(ROW_CYC - 1);
  localparam logic [CNT_W-1:0] L_RAH   = CNT_W'(RAH_CYC - 1);
  localparam logic [CNT_W-1:0] L_COL   = CNT_W'(COL_CYC - 1);
  localparam logic [CNT_W-1:0] L_PRE   = CNT_W'(PRE_CYC - 1);
  localparam logic [CNT_W-1:0] L_CSR   = CNT_W'(CSR_CYC - 1);
  localparam logic [CNT_W-1:0] L_CBR   = CNT_W'(CBR_CYC - 1);

  typedef enum logic [2:0] {
    S_PAUSE, S_IDLE, S_ROW, S_RAH, S_COL, S_CSR, S_CBR, S_PRE
  } state_t;

  state_t            state;
  logic [CNT_W-1:0]  cnt;
  logic              awake;
  logic [WK_W-1:0]   wake_left;
  logic [RC_W-1:0]   ref_cnt;
  logic [ROW_W-1:0]  row_q;
  logic [COL_W-1:0]  col_q;
  logic              wr_q;
  logic [DQ_W-1:0]   wdata_q;

  wire cnt_done = (cnt == '0);
  wire in_ref   = (state == S_CSR) || (state == S_CBR);
  wire ref_pend = awake && (ref_cnt >= RC_W'(REF_INT));
  wire miss     = awake && (ref_cnt == RC_W'(REF_MAX)) && !in_ref;

  assign req_ready   = (state == S_IDLE) && awake && !ref_pend;
  assign dram_ras_n  = !((state == S_RAH) || (state == S_COL) || (state == S_CBR));
  assign dram_cas_n  = !((state == S_COL) || in_ref);
  assign dram_we_n   = !(wr_q && ((state == S_ROW) || (state == S_RAH) || (state == S_COL)));
  assign dram_oe_n   = !(!wr_q && (state == S_COL));
  assign dram_addr   = (state == S_COL) ? ADDR_W'(col_q) : ADDR_W'(row_q);
  assign dram_dq_out = wdata_q;
  assign dram_dq_oe  = wr_q && ((state == S_RAH) || (state == S_COL));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= S_PAUSE;
      cnt       <= L_PAUSE;
      awake     <= 1'b0;
      wake_left <= WK_W'(WAKE_CNT);
      ref_cnt   <= '0;
      row_q     <= '0;
      col_q     <= '0;
      wr_q      <= 1'b0;
      wdata_q   <= '0;
      rd_valid  <= 1'b0;
      rd_data   <= '0;
    end else begin
      rd_valid <= 1'b0;
      if (!awake)                        ref_cnt <= '0;
      else if (ref_cnt != RC_W'(REF_MAX)) ref_cnt <= ref_cnt + 1'b1;
      if (miss) begin
        awake     <= 1'b0;
        wake_left <= WK_W'(WAKE_CNT);
      end
      case (state)
        S_PAUSE: if (cnt_done) state <= S_IDLE; else cnt <= cnt - 1'b1;
        S_IDLE: begin
          if (!awake || ref_pend) begin
            state <= S_CSR;
            cnt   <= L_CSR;
          end else if (req_valid) begin
            row_q   <= req_row;
            col_q   <= req_col;
            wr_q    <= req_write;
            wdata_q <= req_wdata;
            state   <= S_ROW;
            cnt     <= L_ROW;
          end
        end
        S_ROW: if (cnt_done) begin state <= S_RAH; cnt <= L_RAH; end
               else cnt <= cnt - 1'b1;
        S_RAH: if (cnt_done) begin state <= S_COL; cnt <= L_COL; end
               else cnt <= cnt - 1'b1;
        S_COL: begin
          if (cnt_done) begin
            if (!wr_q) begin
              rd_valid <= 1'b1;
              rd_data  <= dram_dq_in;
            end
            state <= S_PRE;
            cnt   <= L_PRE;
          end else cnt <= cnt - 1'b1;
        end
        S_CSR: if (cnt_done) begin state <= S_CBR; cnt <= L_CBR; end
               else cnt <= cnt - 1'b1;
        S_CBR: begin
          if (cnt_done) begin
            state <= S_PRE;
            cnt   <= L_PRE;
            if (!awake) begin
              if (wake_left == WK_W'(1)) awake <= 1'b1;
              wake_left <= wake_left - 1'b1;
            end else begin
              ref_cnt <= '0;
            end
          end else cnt <= cnt - 1'b1;
        end
        S_PRE: if (cnt_done) state <= S_IDLE; else cnt <= cnt - 1'b1;
        default: state <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/fpm_dram_seq_chk.sv
module fpm_dram_seq_chk #(
  parameter int ADDR_W = 11
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_ready,
  input logic              rd_valid,
  input logic [ADDR_W-1:0] dram_addr,
  input logic              dram_ras_n,
  input logic              dram_cas_n,
  input logic              dram_we_n,
  input logic              dram_oe_n
);

  AST_CBR_WE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (!dram_cas_n && dram_ras_n) |-> dram_we_n); // R2

  AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
    (!dram_ras_n || !dram_cas_n) |-> !req_ready); // R4

  AST_ROW_SETUP: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(dram_ras_n) && dram_cas_n) |-> $stable(dram_addr)); // R6

  AST_WRITE_OE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    !dram_we_n |-> dram_oe_n); // R7

  AST_RD_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |=> !rd_valid); // R10

endmodule

bind fpm_dram_seq fpm_dram_seq_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .rd_valid(rd_valid),
  .dram_addr(dram_addr), .dram_ras_n(dram_ras_n), .dram_cas_n(dram_cas_n),
  .dram_we_n(dram_we_n), .dram_oe_n(dram_oe_n)
);

// File: tb/fpm_dram_seq_tb.sv
`timescale 1ns/1ps
module fpm_dram_seq_tb;
  localparam int ROW_W = 11, COL_W = 11, DQ_W = 4, ADDR_W = 11;
  localparam int PAUSE_CYC = 40, WAKE_CNT = 8, REF_INT = 100, REF_MAX = 104;
  localparam int T_RP = 3, T_RAS = 6, T_RAC = 7, T_CAC = 3, T_RAH = 2;
  localparam int T_CP = 2, T_CSR = 1, T_WCS = 3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [ROW_W-1:0] req_row = '0;
  logic [COL_W-1:0] req_col = '0;
  logic [DQ_W-1:0] req_wdata = '0;
  logic req_ready, rd_valid;
  logic [DQ_W-1:0] rd_data, dram_dq_out;
  logic [ADDR_W-1:0] dram_addr;
  logic dram_ras_n, dram_cas_n, dram_we_n, dram_oe_n, dram_dq_oe;
  logic [DQ_W-1:0] dq_drv = '0;

  always #10 clk = ~clk;

  fpm_dram_seq #(.ROW_W(ROW_W), .COL_W(COL_W), .DQ_W(DQ_W), .PAUSE_CYC(PAUSE_CYC),
    .WAKE_CNT(WAKE_CNT), .REF_INT(REF_INT), .REF_MAX(REF_MAX), .T_RP(T_RP),
    .T_RAS(T_RAS), .T_RAC(T_RAC), .T_CAC(T_CAC), .T_RAH(T_RAH), .T_CP(T_CP),
    .T_CSR(T_CSR), .T_WCS(T_WCS)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_row(req_row), .req_col(req_col),
    .req_wdata(req_wdata), .rd_valid(rd_valid), .rd_data(rd_data),
    .dram_addr(dram_addr), .dram_ras_n(dram_ras_n), .dram_cas_n(dram_cas_n),
    .dram_we_n(dram_we_n), .dram_oe_n(dram_oe_n), .dram_dq_out(dram_dq_out),
    .dram_dq_oe(dram_dq_oe), .dram_dq_in(dq_drv));

  int n_chk = 0, n_fail = 0;
  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  logic [3:0] gold [int];
  logic [3:0] mem  [int];
  logic [3:0] exp_q [$];
  int n_req = 0, n_acc = 0, cbr_count = 0;

  // monitor and DRAM model
  logic p_ras = 1, p_cas = 1, p_we = 1, p_rdv = 0;
  int ras_lo = 0, ras_hi = 0, cas_lo = 0, cas_hi = 0, we_lo = 0, neg_cnt = 0;
  logic [ROW_W-1:0] row_l = '0;
  logic [COL_W-1:0] col_l = '0;
  bit row_moved = 0, seen_cmd = 0, seen_ready = 0;

  always @(negedge clk) begin
    if (!rst_n) begin
      neg_cnt = 0;
    end else begin
      neg_cnt++;
      if (!seen_cmd && (!dram_ras_n || !dram_cas_n || !dram_we_n || !dram_oe_n)) begin
        seen_cmd = 1;
        chk(neg_cnt > PAUSE_CYC, "R1", "pause before first strobe", neg_cnt, PAUSE_CYC);
      end
      if (req_ready && !seen_ready) begin
        seen_ready = 1;
        chk(cbr_count == WAKE_CNT, "R2", "refreshes before first ready", cbr_count, WAKE_CNT);
      end
      if (p_ras && !dram_ras_n) begin
        chk(ras_hi >= T_RP, "R9", "RAS precharge", ras_hi, T_RP);
        if (dram_cas_n) begin row_l = dram_addr; row_moved = 0; end
      end
      if (!dram_ras_n && dram_cas_n && !p_ras && dram_addr != ADDR_W'(row_l)) row_moved = 1;
      if (!p_ras && dram_ras_n)
        chk(ras_lo >= T_RAS, "R8", "RAS low time", ras_lo, T_RAS);
      if (p_cas && !dram_cas_n) begin
        chk(cas_hi >= T_CP, "R9", "CAS precharge", cas_hi, T_CP);
        if (dram_ras_n) begin
          cbr_count++;
          chk(dram_we_n == 1'b1, "R2", "WE during CBR", dram_we_n, 1);
        end else begin
          n_acc++;
          col_l = dram_addr;
          chk(!row_moved && ras_lo >= T_RAH, "R6", "row hold before column", ras_lo, T_RAH);
          if (!dram_we_n) begin
            chk(we_lo >= T_WCS, "R7", "WE setup", we_lo, T_WCS);
            chk(dram_dq_oe && dram_oe_n, "R7", "write drive/OE", {dram_dq_oe, dram_oe_n}, 3);
            mem[{row_l, col_l}] = dram_dq_out;
          end else begin
            chk(!dram_oe_n, "R8", "OE low on read", dram_oe_n, 0);
          end
        end
      end
      if (rd_valid) begin
        chk(!p_rdv, "R10", "rd_valid width", 2, 1);
        if (exp_q.size() == 0) chk(0, "R10", "unexpected rd_valid", 1, 0);
        else begin
          logic [3:0] e;
          e = exp_q.pop_front();
          chk(rd_data == e, "R8", "read data", rd_data, e);
        end
      end
      if (!dram_ras_n) begin ras_lo = p_ras ? 1 : ras_lo + 1; ras_hi = 0; end
      else begin ras_hi = p_ras ? ras_hi + 1 : 1; ras_lo = 0; end
      if (!dram_cas_n) begin cas_lo = p_cas ? 1 : cas_lo + 1; cas_hi = 0; end
      else begin cas_hi = p_cas ? cas_hi + 1 : 1; cas_lo = 0; end
      we_lo = dram_we_n ? 0 : we_lo + 1;
      if (!dram_ras_n && !dram_cas_n && !dram_oe_n && dram_we_n) begin
        logic [3:0] v;
        v = mem.exists({row_l, col_l}) ? mem[{row_l, col_l}] : 4'h0;
        dq_drv = (cas_lo >= T_CAC && ras_lo >= T_RAC) ? v : ~v;
      end else dq_drv = 4'h0;
      p_ras = dram_ras_n; p_cas = dram_cas_n; p_we = dram_we_n; p_rdv = rd_valid;
    end
  end

  // driver: called at a negedge
  task automatic host_op(input bit wr, input int row, input int col, input logic [3:0] d);
    req_valid = 1; req_write = wr;
    req_row = ROW_W'(row); req_col = COL_W'(col); req_wdata = d;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 0;
    n_req++;
    if (wr) gold[{ROW_W'(row), COL_W'(col)}] = d;
    else exp_q.push_back(gold.exists({ROW_W'(row), COL_W'(col)}) ?
                         gold[{ROW_W'(row), COL_W'(col)}] : 4'h0);
  endtask

  task automatic wait_ref_end();
    do @(negedge clk); while (!(!dram_cas_n && dram_ras_n));
    do @(negedge clk); while (dram_ras_n);
    do @(negedge clk); while (!dram_ras_n);
  endtask

  task automatic wait_ready();
    while (!req_ready) @(negedge clk);
  endtask

  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      chk(0, "WD", "watchdog", cyc, 100000);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk({dram_ras_n, dram_cas_n, dram_we_n, dram_oe_n} == 4'hF, "R1", "strobes in reset",
        {dram_ras_n, dram_cas_n, dram_we_n, dram_oe_n}, 15);
    chk(!req_ready && !rd_valid, "R1", "ready/valid in reset", {req_ready, rd_valid}, 0);
    rst_n = 1;
    wait_ready();
    // main function: varied patterns
    host_op(1, 0, 0, 4'h5);
    host_op(1, 2047, 2047, 4'hA);
    host_op(1, 1365, 682, 4'hF);
    host_op(1, 682, 1365, 4'h0);
    host_op(0, 0, 0, 0);
    host_op(0, 2047, 2047, 0);
    host_op(0, 1365, 682, 0);
    host_op(0, 682, 1365, 0);
    host_op(1, 0, 0, 4'h3);
    host_op(0, 0, 0, 0);
    // R3: idle refresh spacing
    wait_ref_end();
    begin
      int n = 0;
      while (!(!dram_cas_n && dram_ras_n)) begin @(negedge clk); n++; end
      chk(n == REF_INT + 1, "R3", "idle refresh spacing", n, REF_INT + 1);
      chk(!req_ready, "R3", "ready during refresh", req_ready, 0);
    end
    // R4: request raised during a refresh waits
    chk(!req_ready, "R4", "ready while CBR active", req_ready, 0);
    host_op(0, 2047, 2047, 0);
    // R5 boundary: refresh due mid-access, started before deadline
    wait_ref_end();
    repeat (89) @(negedge clk);
    begin
      int c0;
      host_op(0, 1365, 682, 0);
      c0 = cbr_count;
      wait_ready();
      chk(cbr_count - c0 == 1, "R5", "refresh count, deadline met", cbr_count - c0, 1);
    end
    // R5: deadline missed inside an access
    wait_ref_end();
    repeat (96) @(negedge clk);
    begin
      int c0;
      host_op(0, 682, 1365, 0);
      c0 = cbr_count;
      wait_ready();
      chk(cbr_count - c0 == WAKE_CNT, "R5", "wake rerun after miss", cbr_count - c0, WAKE_CNT);
    end
    host_op(0, 0, 0, 0);
    host_op(1, 100, 200, 4'h9);
    host_op(0, 100, 200, 0);
    repeat (30) @(negedge clk);
    chk(exp_q.size() == 0, "R10", "reads outstanding", exp_q.size(), 0);
    chk(n_acc == n_req, "R11", "accesses per request", n_acc, n_req);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule